// File: doc/BRIEF.md
# Serial Port Register Front End

This block lets a processor reach a serial port through three 32-bit word registers. It sits on a simple word-access bus inside a 24-byte window. On the character side it drives a byte-wide transmit stream and takes bytes from a byte-wide receive stream, and both streams use valid/ready handshakes. Bit timing, baud generation, interrupts and queueing are left to the logic on the far side of the streams.

A write to the transmit register sends the low byte of the write data downstream as a one-cycle valid pulse. Software checks the transmit-ready status bit before it writes. This bit follows the downstream ready input directly.

The receive side holds one byte. When a byte arrives, the block keeps it and raises the receive-ready status bit. It then holds its stream ready output low until software reads the receive register, so a byte never overwrites one that has not been read. That read returns the byte and clears the flag in the same access. The status register cannot be written.

Top module: `ser_reg_front`

## Requirements
- R1: After reset, bus read data is zero, the transmit valid output is low, the receive stream ready output is high, the held receive byte reads as zero and the receive-ready flag is clear.
- R2: The status register is at byte offset 0x14. Bit 0 is the receive-ready flag. Bit 1 equals the transmit stream ready input at the time of the read. All other bits read as zero.
- R3: When the receive valid input and the receive ready output are both high at a clock edge, the byte is stored and status bit 0 becomes 1.
- R4: While the receive-ready flag is set, the receive ready output is low. Bytes presented on the receive stream are not taken, and the held byte does not change.
- R5: A read of the receive data register (offset 0x04) returns the held byte in bits 7:0 with zeros above. The same read clears the receive-ready flag, so the receive ready output is high in the next cycle.
- R6: In a cycle that has a read of the receive data register, the receive ready output is low. An incoming byte in that cycle is held off and is taken one cycle later.
- R7: A write to the transmit data register (offset 0x00) raises the transmit valid output for exactly one cycle after the write. During that cycle the transmit data output carries bits 7:0 of the write data.
- R8: A write to the status register changes no state. The flag, the held byte and the transmit output are unaffected.
- R9: Access decodes only when address bits 1:0 are zero and the address is inside the window. A read of any other offset, an unaligned address or an address outside the window returns zero. A write to any of these is dropped and produces no transmit pulse.
- R10: Read data is registered and appears the cycle after the read request. It keeps its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid (one-cycle pulse) |
| tx_ready | input | 1 | Downstream can take a byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is valid |
| rx_ready | output | 1 | Block can take a received byte |

## Verification
The receive path is tested with several timings:
- a byte offered while the holder is empty;
- a second byte offered while it is full, which separates backpressure from overwrite;
- a byte offered in the same cycle as the receive read, which shows whether the read takes priority;
- a byte kept valid across that read, which shows that it is taken one cycle later.

The transmit path is tested with a full 32-bit write word, to confirm that only the low byte passes through. Unaligned and out-of-window transmit writes must produce no pulse. Status is read with the downstream ready high and then low, and again after a status write, to separate the live ready bit from stored state.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned WIN_BYTES = 24;
  localparam int unsigned IDX_TXD   = 0;
  localparam int unsigned IDX_RXD   = 1;
  localparam int unsigned IDX_STAT  = 5;
  localparam int unsigned STAT_RXF  = 0;
  localparam int unsigned STAT_TXR  = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TXD  = 2'd1,
    SEL_RXD  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  // Status word: only the two defined bits may be set.
  function automatic logic [31:0] status_word(input logic rx_full, input logic tx_rdy);
    logic [31:0] w;
    w = '0;
    w[STAT_RXF] = rx_full;
    w[STAT_TXR] = tx_rdy;
    return w;
  endfunction

  // Zero-extend a byte into a bus word.
  function automatic logic [31:0] byte_word(input logic [7:0] b);
    return {24'd0, b};
  endfunction
endpackage

// File: rtl/ser_addr_decode.sv
module ser_addr_decode
  import ser_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          target,
  output logic              rd_evt,
  output logic              wr_txd_evt,
  output logic              rd_rxd_evt
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             aligned;
  logic             in_win;
  logic [IDX_W-1:0] idx;

  assign aligned = (addr[1:0] == 2'b00);
  assign in_win  = (addr < ADDR_W'(WIN_BYTES));
  assign idx     = addr[ADDR_W-1:2];

  always_comb begin
    target = SEL_NONE;
    if (aligned && in_win) begin
      if (idx == IDX_W'(IDX_TXD))       target = SEL_TXD;
      else if (idx == IDX_W'(IDX_RXD))  target = SEL_RXD;
      else if (idx == IDX_W'(IDX_STAT)) target = SEL_STAT;
    end
  end

  assign rd_evt     = sel && !we;
  assign wr_txd_evt = sel && we && (target == SEL_TXD);
  assign rd_rxd_evt = sel && !we && (target == SEL_RXD);

  a_r9_unaligned_nohit: assert property (@(posedge sel) addr[1:0] != 2'b00 |-> target == SEL_NONE);
endmodule

// File: rtl/ser_rx_hold.sv
module ser_rx_hold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              clr_evt,
  output logic              held,
  output logic [BYTE_W-1:0] byte_q
);
  logic accept_evt;

  // A read of the holder in this cycle takes priority over any arrival.
  assign in_ready   = !held && !clr_evt;
  assign accept_evt = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      byte_q <= '0;
    end else begin
      if (accept_evt) begin
        held   <= 1'b1;
        byte_q <= in_data;
      end else if (clr_evt) begin
        held <= 1'b0;
      end
    end
  end

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> held && byte_q == $past(in_data));
  a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    held && !clr_evt |=> held && $stable(byte_q));
  a_r4_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !in_ready);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    held && clr_evt |=> !held && in_ready == !clr_evt);
endmodule

// File: rtl/ser_tx_issue.sv
module ser_tx_issue #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= wr_evt;
      if (wr_evt) out_data <= wr_byte;
    end
  end

  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> out_valid && out_data == $past(wr_byte));
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> !out_valid);
endmodule

// File: rtl/ser_reg_front.sv
module ser_reg_front
  import ser_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready
);
  reg_sel_e          target;
  logic              rd_evt;
  logic              wr_txd_evt;
  logic              rd_rxd_evt;
  logic              rx_held;
  logic [BYTE_W-1:0] rx_byte;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:BYTE_W];

  ser_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel        (bus_sel),
    .we         (bus_we),
    .addr       (bus_addr),
    .target     (target),
    .rd_evt     (rd_evt),
    .wr_txd_evt (wr_txd_evt),
    .rd_rxd_evt (rd_rxd_evt)
  );

  ser_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (rx_data),
    .in_valid (rx_valid),
    .in_ready (rx_ready),
    .clr_evt  (rd_rxd_evt),
    .held     (rx_held),
    .byte_q   (rx_byte)
  );

  ser_tx_issue #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_evt    (wr_txd_evt),
    .wr_byte   (bus_wdata[BYTE_W-1:0]),
    .out_data  (tx_data),
    .out_valid (tx_valid)
  );

  always_comb begin
    case (target)
      SEL_RXD:  rd_mux = DATA_W'(byte_word(8'(rx_byte)));
      SEL_STAT: rd_mux = DATA_W'(status_word(rx_held, tx_ready));
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_evt) bus_rdata <= rd_mux;
  end

  a_r6_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rxd_evt |-> !rx_ready);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(bus_rdata));
  a_r8_stat_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && target == SEL_STAT && !(rx_valid && rx_ready) |=> $stable(rx_held) && $stable(rx_byte) && !tx_valid);
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:BYTE_W] == '0);
endmodule

// File: tb/tb_ser_reg_front.sv
module tb_ser_reg_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  ser_reg_front dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  function automatic logic [31:0] exp_status(input logic full, input logic txr);
    return {30'd0, txr, full};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, output logic took);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 took = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(bus_rdata == 32'd0, "R1 rdata", bus_rdata, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", {31'd0, tx_valid}, 0);
    chk(rx_ready == 1'b1, "R1 rx_ready", {31'd0, rx_ready}, 1);
    bus_read(5'h14, rd);
    chk(rd == exp_status(0, 1), "R1 status", rd, exp_status(0, 1));
    bus_read(5'h04, rd);
    chk(rd == 32'd0, "R1 rx byte", rd, 0);
  endtask

  task automatic t_status_txr();
    tx_ready = 1'b0;
    bus_read(5'h14, rd);
    chk(rd == exp_status(0, 0), "R2 txr low", rd, exp_status(0, 0));
    tx_ready = 1'b1;
    bus_read(5'h14, rd);
    chk(rd == exp_status(0, 1), "R2 txr high", rd, exp_status(0, 1));
  endtask

  task automatic t_rx_and_backpressure();
    logic took;
    push(8'hA5, took);
    chk(took == 1'b1, "R3 taken", {31'd0, took}, 1);
    bus_read(5'h14, rd);
    chk(rd == exp_status(1, 1), "R3 flag set", rd, exp_status(1, 1));
    push(8'h3C, took);
    chk(took == 1'b0, "R4 ready low", {31'd0, took}, 0);
    bus_read(5'h04, rd);
    chk(rd == 32'h0000_00A5, "R4 R5 byte kept", rd, 32'hA5);
    #1 chk(rx_ready == 1'b1, "R5 ready back", {31'd0, rx_ready}, 1);
    bus_read(5'h14, rd);
    chk(rd == exp_status(0, 1), "R5 flag clear", rd, exp_status(0, 1));
  endtask

  task automatic t_read_wins();
    logic took;
    push(8'h11, took);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'h04;
    rx_valid = 1'b1; rx_data = 8'h22;
    #1 chk(rx_ready == 1'b0, "R6 ready low on read", {31'd0, rx_ready}, 0);
    @(negedge clk);
    bus_sel = 1'b0;
    chk(bus_rdata == 32'h11, "R6 old byte read", bus_rdata, 32'h11);
    #1 chk(rx_ready == 1'b1, "R6 ready next cycle", {31'd0, rx_ready}, 1);
    @(negedge clk);
    rx_valid = 1'b0;
    bus_read(5'h04, rd);
    chk(rd == 32'h22, "R6 deferred byte", rd, 32'h22);
  endtask

  task automatic t_tx();
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h00; bus_wdata = 32'hABCD_1234;
    #1 chk(tx_valid == 1'b0, "R7 not before edge", {31'd0, tx_valid}, 0);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chk(tx_valid == 1'b1, "R7 pulse", {31'd0, tx_valid}, 1);
    chk(tx_data == 8'h34, "R7 low byte", {24'd0, tx_data}, 32'h34);
    @(negedge clk);
    chk(tx_valid == 1'b0, "R7 one cycle", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_status_write();
    logic took;
    push(8'h5A, took);
    bus_write(5'h14, 32'h0000_0000);
    chk(tx_valid == 1'b0, "R8 no tx", {31'd0, tx_valid}, 0);
    bus_read(5'h14, rd);
    chk(rd == exp_status(1, 1), "R8 flag kept", rd, exp_status(1, 1));
    bus_read(5'h04, rd);
    chk(rd == 32'h5A, "R8 byte kept", rd, 32'h5A);
  endtask

  task automatic t_unmapped();
    bus_read(5'h14, rd);
    bus_read(5'h08, rd);
    chk(rd == 32'd0, "R9 gap read", rd, 0);
    bus_read(5'h14, rd);
    bus_read(5'h05, rd);
    chk(rd == 32'd0, "R9 unaligned read", rd, 0);
    bus_write(5'h01, 32'h77);
    chk(tx_valid == 1'b0, "R9 unaligned write", {31'd0, tx_valid}, 0);
    bus_write(5'h18, 32'h77);
    chk(tx_valid == 1'b0, "R9 out of window write", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_rdata_hold();
    logic took;
    push(8'h6E, took);
    bus_read(5'h04, rd);
    repeat (3) @(negedge clk);
    chk(bus_rdata == 32'h6E, "R10 hold", bus_rdata, 32'h6E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status_txr();
    t_rx_and_backpressure();
    t_read_wins();
    t_tx();
    t_status_write();
    t_unmapped();
    t_rdata_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule